// File: doc/BRIEF.md
# Multidrop Receive Preamble Synchronizer

This block sits behind a bit aligner in the receive path of a multidrop single-pair PHY. Each cycle it may take one 5-bit code group, with a valid strobe and a lock indication from the aligner. A small state machine watches the stream for three things: beacon pairs, sync/commit preambles, and the start-of-stream delimiter, which is two delimiter code groups in a row. It reports each with a one-cycle flag. A broken sequence with an invalid code group raises an error flag and sends the machine back to its idle wait.

Two consecutive beacons that reach the aligner with bits slipped can be framed as two consecutive delimiter code groups. In legacy mode the idle wait accepts a delimiter directly. That covers a receiver whose lock used up the whole preamble, but it also lets a slipped beacon pass as a frame start. In hardened mode, which a configuration input selects, a sync code group has to come first. This is safe because a transmitter always sends at least two sync or commit code groups ahead of the delimiter.

Top module: `rx_preamble_sync`

## Requirements
- R1: While `rst` is high, or in the cycle after `sym_lock` is low, the machine is in its idle wait and all three flags are low. Reset is synchronous and active high.
- R2: Code groups are numbered with bit 0 as the first bit received. The default values are SYNC 5'h03, COMMIT 5'h11, BEACON 5'h02 and SSD 5'h04, and each can be changed by a parameter.
- R3: In the idle wait, SYNC moves to the syncing state and BEACON moves to the first-beacon state. In legacy mode (`harden_en`=0), SSD moves straight to the delimiter wait.
- R4: In hardened mode (`harden_en`=1), SSD in the idle wait is ignored. The delimiter wait can then be entered only from the syncing state.
- R5: The syncing state stays put while SYNC or COMMIT arrives and moves to the delimiter wait on SSD. Any other valid code group sends it back to the idle wait.
- R6: A BEACON taken in the first-beacon state raises `beacon_detected` for exactly one cycle, the cycle after that code group is accepted. Any other code group in the first-beacon state returns the machine to the idle wait with no flag.
- R7: An SSD taken in the delimiter wait raises `frame_start` for exactly one cycle, the cycle after acceptance. Any other code group there returns the machine to the idle wait.
- R8: An invalid code group raises `sync_error` for one cycle and returns the machine to the idle wait when it arrives outside the idle wait. Invalid means clear in the `VALID_MAP` parameter, which by default is 5'h00 and 5'h1F. In the idle wait an invalid code group has no effect.
- R9: A cycle with `sym_valid` low leaves the state unchanged and raises no flag.
- R10: At most one flag is high in any cycle.
- R11: A run of beacons with its leading bits slipped by four positions frames as repeated SSD code groups. That run produces `frame_start` in legacy mode and never in hardened mode, and real beacons that follow are still detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| harden_en | input | 1 | 1 selects hardened mode, where SYNC is required before SSD |
| sym_lock | input | 1 | Aligner holds symbol and bit lock |
| sym_valid | input | 1 | `sym_code` carries a code group this cycle |
| sym_code | input | 5 | Aligned code group, bit 0 received first |
| beacon_detected | output | 1 | One-cycle pulse after a beacon pair |
| frame_start | output | 1 | One-cycle pulse after a complete delimiter |
| sync_error | output | 1 | One-cycle pulse on an invalid code group outside the idle wait |

## Verification
The bench feeds a slipped beacon run in both modes. A design that ignores the mode bit would either report a frame start in hardened mode or miss the one legacy mode is meant to produce. It also sends a single SSD in hardened mode and then a second one, where a design that lets the first SSD through would report a frame. It breaks a preamble with an ordinary code group and then sends SSD SSD in hardened mode, where a design that fails to return to the idle wait would report a frame. Finally it tests invalid code groups in the idle wait and elsewhere, gaps in the valid strobe, and a short loss of lock. A wrong error rule, a state that moves on a gap, or state kept across lock loss each shows up as a flag in a cycle the requirements forbid.

// File: rtl/rx_sync_pkg.sv
package rx_sync_pkg;

  localparam int SYM_W   = 5;
  localparam int CODE_N  = 1 << SYM_W;

  typedef enum logic [1:0] {
    ST_WAIT    = 2'd0,
    ST_SYNCING = 2'd1,
    ST_BEACON1 = 2'd2,
    ST_DELIM   = 2'd3
  } sync_state_e;

  typedef enum logic [2:0] {
    SK_SYNC   = 3'd0,
    SK_COMMIT = 3'd1,
    SK_BEACON = 3'd2,
    SK_SSD    = 3'd3,
    SK_OTHER  = 3'd4,
    SK_BAD    = 3'd5
  } sym_kind_e;

  typedef struct packed {
    sync_state_e nxt;
    logic        ev_beacon;
    logic        ev_frame;
    logic        ev_error;
  } step_t;

  // Map a code group to its role; invalidity is checked first.
  function automatic sym_kind_e classify_sym(
    input logic [SYM_W-1:0]  code,
    input logic [SYM_W-1:0]  c_sync,
    input logic [SYM_W-1:0]  c_commit,
    input logic [SYM_W-1:0]  c_beacon,
    input logic [SYM_W-1:0]  c_ssd,
    input logic [CODE_N-1:0] vmap
  );
    if (!vmap[code])           return SK_BAD;
    else if (code == c_sync)   return SK_SYNC;
    else if (code == c_commit) return SK_COMMIT;
    else if (code == c_beacon) return SK_BEACON;
    else if (code == c_ssd)    return SK_SSD;
    else                       return SK_OTHER;
  endfunction

  // One accepted code group: next state and the event it produces.
  function automatic step_t sync_step(
    input sync_state_e cur,
    input sym_kind_e   k,
    input logic        harden
  );
    step_t s;
    s.nxt       = cur;
    s.ev_beacon = 1'b0;
    s.ev_frame  = 1'b0;
    s.ev_error  = 1'b0;
    unique case (cur)
      ST_WAIT: begin
        if (k == SK_SYNC)                s.nxt = ST_SYNCING;
        else if (k == SK_BEACON)         s.nxt = ST_BEACON1;
        else if (k == SK_SSD && !harden) s.nxt = ST_DELIM;
      end
      ST_SYNCING: begin
        if (k == SK_SYNC || k == SK_COMMIT) s.nxt = ST_SYNCING;
        else if (k == SK_SSD)               s.nxt = ST_DELIM;
        else begin
          s.nxt      = ST_WAIT;
          s.ev_error = (k == SK_BAD);
        end
      end
      ST_BEACON1: begin
        s.nxt       = ST_WAIT;
        s.ev_beacon = (k == SK_BEACON);
        s.ev_error  = (k == SK_BAD);
      end
      ST_DELIM: begin
        s.nxt      = ST_WAIT;
        s.ev_frame = (k == SK_SSD);
        s.ev_error = (k == SK_BAD);
      end
      default: s.nxt = ST_WAIT;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rx_sym_classify.sv
module rx_sym_classify
  import rx_sync_pkg::*;
#(
  parameter logic [SYM_W-1:0]  CODE_SYNC   = 5'h03,
  parameter logic [SYM_W-1:0]  CODE_COMMIT = 5'h11,
  parameter logic [SYM_W-1:0]  CODE_BEACON = 5'h02,
  parameter logic [SYM_W-1:0]  CODE_SSD    = 5'h04,
  parameter logic [CODE_N-1:0] VALID_MAP   = 32'h7FFF_FFFE
) (
  input  logic [SYM_W-1:0] code,
  output sym_kind_e        kind
);
  always_comb begin
    kind = classify_sym(code, CODE_SYNC, CODE_COMMIT, CODE_BEACON,
                        CODE_SSD, VALID_MAP);
  end
endmodule

// File: rtl/rx_sync_core.sv
module rx_sync_core
  import rx_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        harden_en,
  input  logic        sym_lock,
  input  logic        sym_valid,
  input  sym_kind_e   kind,
  output sync_state_e state_q,
  output logic        ev_beacon,
  output logic        ev_frame,
  output logic        ev_error
);
  step_t step;
  logic  take;

  assign take = sym_valid && sym_lock && !rst;

  always_comb begin
    step = sync_step(state_q, kind, harden_en);
  end

  assign ev_beacon = take && step.ev_beacon;
  assign ev_frame  = take && step.ev_frame;
  assign ev_error  = take && step.ev_error;

  always_ff @(posedge clk) begin
    if (rst || !sym_lock) state_q <= ST_WAIT;
    else if (sym_valid)   state_q <= step.nxt;
  end
endmodule

// File: rtl/rx_sync_flags.sv
module rx_sync_flags #(
  parameter int N_FLAGS = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_FLAGS-1:0] ev,
  output logic [N_FLAGS-1:0] flag_q
);
  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= ev[i];
    end
  end
endmodule

// File: rtl/rx_preamble_sync.sv
module rx_preamble_sync
  import rx_sync_pkg::*;
#(
  parameter logic [SYM_W-1:0]  CODE_SYNC   = 5'h03,
  parameter logic [SYM_W-1:0]  CODE_COMMIT = 5'h11,
  parameter logic [SYM_W-1:0]  CODE_BEACON = 5'h02,
  parameter logic [SYM_W-1:0]  CODE_SSD    = 5'h04,
  parameter logic [CODE_N-1:0] VALID_MAP   = 32'h7FFF_FFFE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             harden_en,
  input  logic             sym_lock,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym_code,
  output logic             beacon_detected,
  output logic             frame_start,
  output logic             sync_error
);
  localparam int N_FLAGS = 3;

  sym_kind_e          sym_kind;
  sync_state_e        state_q;
  logic               ev_beacon, ev_frame, ev_error;
  logic [N_FLAGS-1:0] flags;

  rx_sym_classify #(
    .CODE_SYNC(CODE_SYNC), .CODE_COMMIT(CODE_COMMIT),
    .CODE_BEACON(CODE_BEACON), .CODE_SSD(CODE_SSD),
    .VALID_MAP(VALID_MAP)
  ) u_class (
    .code (sym_code),
    .kind (sym_kind)
  );

  rx_sync_core u_core (
    .clk       (clk),
    .rst       (rst),
    .harden_en (harden_en),
    .sym_lock  (sym_lock),
    .sym_valid (sym_valid),
    .kind      (sym_kind),
    .state_q   (state_q),
    .ev_beacon (ev_beacon),
    .ev_frame  (ev_frame),
    .ev_error  (ev_error)
  );

  rx_sync_flags #(.N_FLAGS(N_FLAGS)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .ev     ({ev_error, ev_frame, ev_beacon}),
    .flag_q (flags)
  );

  assign beacon_detected = flags[0];
  assign frame_start     = flags[1];
  assign sync_error      = flags[2];
endmodule

// File: rtl/rx_sync_checker.sv
module rx_sync_checker
  import rx_sync_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        harden_en,
  input logic        sym_lock,
  input logic        sym_valid,
  input sym_kind_e   sym_kind,
  input sync_state_e state_q,
  input logic        beacon_detected,
  input logic        frame_start,
  input logic        sync_error
);
  a_r1_lock_loss_clears: assert property (@(posedge clk) disable iff (rst)
    !sym_lock |=> (state_q == ST_WAIT && !beacon_detected && !frame_start && !sync_error));

  a_r4_hard_ssd_ignored: assert property (@(posedge clk) disable iff (rst)
    (harden_en && sym_lock && sym_valid && state_q == ST_WAIT && sym_kind == SK_SSD)
      |=> state_q == ST_WAIT);

  a_r4_delim_via_sync: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DELIM && $past(state_q) != ST_DELIM && $past(harden_en))
      |-> $past(state_q) == ST_SYNCING);

  a_r6_beacon_origin: assert property (@(posedge clk) disable iff (rst)
    beacon_detected |-> ($past(state_q) == ST_BEACON1 && $past(sym_kind) == SK_BEACON
                         && $past(sym_valid)));

  a_r7_frame_origin: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> ($past(state_q) == ST_DELIM && $past(sym_kind) == SK_SSD
                     && $past(sym_valid)));

  a_r8_error_returns: assert property (@(posedge clk) disable iff (rst)
    sync_error |-> (state_q == ST_WAIT && $past(state_q) != ST_WAIT
                    && $past(sym_kind) == SK_BAD));

  a_r9_gap_holds: assert property (@(posedge clk) disable iff (rst)
    (sym_lock && !sym_valid) |=> ($stable(state_q) && !beacon_detected
                                  && !frame_start && !sync_error));

  a_r10_one_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({beacon_detected, frame_start, sync_error}));
endmodule

bind rx_preamble_sync rx_sync_checker u_chk (
  .clk             (clk),
  .rst             (rst),
  .harden_en       (harden_en),
  .sym_lock        (sym_lock),
  .sym_valid       (sym_valid),
  .sym_kind        (sym_kind),
  .state_q         (state_q),
  .beacon_detected (beacon_detected),
  .frame_start     (frame_start),
  .sync_error      (sync_error)
);

// File: tb/rx_preamble_sync_test.sv
`timescale 1ns/1ps
module rx_preamble_sync_test;
  localparam logic [4:0] C_SYNC = 5'h03, C_COMMIT = 5'h11, C_BEACON = 5'h02,
                         C_SSD = 5'h04, C_OTHER = 5'h0A, C_BAD0 = 5'h00, C_BAD1 = 5'h1F;

  logic clk = 1'b0;
  logic rst = 1'b1, harden_en = 1'b0, sym_lock = 1'b1, sym_valid = 1'b0;
  logic [4:0] sym_code = '0;
  logic beacon_detected, frame_start, sync_error;
  logic fb, ff, fe;
  int   n_checks = 0, n_errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  rx_preamble_sync uut (
    .clk(clk), .rst(rst), .harden_en(harden_en), .sym_lock(sym_lock),
    .sym_valid(sym_valid), .sym_code(sym_code),
    .beacon_detected(beacon_detected), .frame_start(frame_start),
    .sync_error(sync_error)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle, then snapshot flags 2 ns after the edge.
  task automatic cyc(input logic v, input logic [4:0] c);
    @(negedge clk);
    sym_valid = v;
    sym_code  = c;
    @(posedge clk);
    #2;
    fb = beacon_detected; ff = frame_start; fe = sync_error;
  endtask

  task automatic send(input logic [4:0] c); cyc(1'b1, c); endtask
  task automatic gap(); cyc(1'b0, 5'h00); endtask

  task automatic flags_are(input string req, input string what,
                           input logic b, input logic f, input logic e);
    chk(req, {what, " beacon"}, int'(fb), int'(b));
    chk(req, {what, " frame"},  int'(ff), int'(f));
    chk(req, {what, " error"},  int'(fe), int'(e));
  endtask

  // An ordinary valid code group returns every state to the idle wait.
  task automatic flush(); send(C_OTHER); gap(); endtask

  task automatic t_reset();
    rst = 1'b1; gap(); gap();
    flags_are("R1", "in reset", 0, 0, 0);
    rst = 1'b0; gap();
    flags_are("R1", "after reset", 0, 0, 0);
  endtask

  task automatic t_preamble();
    harden_en = 1'b0; flush();
    send(C_SYNC); send(C_SYNC); send(C_COMMIT);
    flags_are("R5", "preamble", 0, 0, 0);
    send(C_SSD);
    flags_are("R5", "first ssd", 0, 0, 0);
    send(C_SSD);
    flags_are("R7", "second ssd", 0, 1, 0);
    gap();
    chk("R7", "frame one cycle", int'(ff), 0);
  endtask

  task automatic t_legacy_direct();
    harden_en = 1'b0; flush();
    send(C_SSD);
    chk("R3", "direct ssd no flag", int'(ff), 0);
    send(C_SSD);
    chk("R3", "direct delim frame", int'(ff), 1);
  endtask

  task automatic t_hard_ssd();
    harden_en = 1'b1; flush();
    send(C_SSD); send(C_SSD);
    chk("R4", "ssd ssd in idle ignored", int'(ff), 0);
    send(C_SSD);
    chk("R4", "third ssd ignored", int'(ff), 0);
    send(C_SYNC); send(C_SSD); send(C_SSD);
    chk("R4", "sync then delimiter", int'(ff), 1);
  endtask

  task automatic t_sync_break();
    harden_en = 1'b1; flush();
    send(C_SYNC); send(C_OTHER); send(C_SSD); send(C_SSD);
    chk("R5", "broken preamble no frame", int'(ff), 0);
    send(C_SYNC); send(C_BEACON); send(C_SSD); send(C_SSD);
    chk("R5", "beacon in syncing leaves", int'(ff), 0);
  endtask

  task automatic t_beacon();
    harden_en = 1'b0; flush();
    send(C_BEACON);
    chk("R6", "first beacon no flag", int'(fb), 0);
    send(C_BEACON);
    flags_are("R6", "beacon pair", 1, 0, 0);
    gap();
    chk("R6", "beacon one cycle", int'(fb), 0);
    send(C_BEACON); send(C_SYNC);
    chk("R6", "beacon broken", int'(fb), 0);
    send(C_BEACON);
    chk("R6", "restart beacon1", int'(fb), 0);
    send(C_BEACON);
    chk("R6", "second pair", int'(fb), 1);
  endtask

  task automatic t_invalid();
    harden_en = 1'b1; flush();
    send(C_BAD1);
    chk("R8", "invalid in idle no error", int'(fe), 0);
    send(C_SYNC); send(C_BAD0);
    flags_are("R8", "invalid in syncing", 0, 0, 1);
    send(C_SSD); send(C_SSD);
    chk("R8", "idle after error", int'(ff), 0);
    send(C_SYNC); send(C_SSD); send(C_BAD1);
    chk("R8", "invalid in delim", int'(fe), 1);
    send(C_BEACON); send(C_BAD0);
    flags_are("R8", "invalid in beacon1", 0, 0, 1);
  endtask

  task automatic t_gaps();
    harden_en = 1'b1; flush();
    send(C_SYNC); gap(); gap();
    flags_are("R9", "gap in syncing", 0, 0, 0);
    send(C_SSD); gap();
    flags_are("R9", "gap in delim", 0, 0, 0);
    send(C_SSD);
    chk("R9", "delim kept across gap", int'(ff), 1);
  endtask

  task automatic t_lock();
    harden_en = 1'b1; flush();
    send(C_SYNC); send(C_SSD);
    @(negedge clk); sym_lock = 1'b0; sym_valid = 1'b1; sym_code = C_SSD;
    @(posedge clk); #2;
    flags_are("R1", "ssd during lock loss", 0, 0, 0);
    sym_lock = 1'b1;
    send(C_SSD);
    chk("R1", "state cleared by lock loss", int'(ff), 0);
  endtask

  task automatic t_codes();
    harden_en = 1'b0; flush();
    send(5'b00100);
    send(5'b00100);
    chk("R2", "ssd bit pattern 00100", int'(ff), 1);
    send(5'b00010); send(5'b00010);
    chk("R2", "beacon bit pattern 01000 lsb first", int'(fb), 1);
  endtask

  // Beacon stream with four leading bits lost, reframed by the aligner.
  function automatic logic [4:0] slipped_sym(input int k);
    logic [4:0] s;
    for (int j = 0; j < 5; j++) s[j] = C_BEACON[(4 + 5*k + j) % 5];
    return s;
  endfunction

  task automatic t_slip(input logic hard, input int exp_frames);
    int frames = 0;
    harden_en = hard; flush();
    chk("R11", "slipped beacon frames as ssd", int'(slipped_sym(0)), int'(C_SSD));
    for (int k = 0; k < 5; k++) begin
      send(slipped_sym(k));
      if (ff) frames++;
    end
    chk("R11", hard ? "hardened false frames" : "legacy false frames", frames, exp_frames);
    flush();
    send(C_BEACON); send(C_BEACON);
    chk("R11", "true beacon after resync", int'(fb), 1);
  endtask

  initial begin
    t_reset();
    t_preamble();
    t_legacy_direct();
    t_hard_ssd();
    t_sync_break();
    t_beacon();
    t_invalid();
    t_gaps();
    t_lock();
    t_codes();
    t_slip(1'b0, 2);
    t_slip(1'b1, 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule